// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer

This block is a bank of independent countdown timers behind a flat register bus. A shared prescaler turns the system clock into a one-cycle tick at 1 MHz. Every channel counts those ticks down from a programmed start value and raises its own level interrupt when it runs out. A channel runs either once (one-shot) or forever, reloading its start value at the end of each period (continuous).

Software programs the start value as the wanted number of ticks minus one. It starts a channel by writing its configuration register with the enable bit set. Rewriting that register acknowledges the interrupt, and writing zero there stops the channel. Reads return the configuration, the pending state, the programmed start value and the live count. Interrupt routing and masking sit outside this block.

Top module: `interval_timer_bank`

## Requirements
- R1: The prescaler produces a one-cycle tick on every DIV-th rising clock edge after reset is released, that is, on edges DIV, 2·DIV, 3·DIV and so on, counting the first edge after release as edge 1.
- R2: Channel c occupies byte addresses c·0x10 to c·0x10+0xF. Address bit 3 selects the configuration register (0) or the count register (1). Address bits [2:0] are ignored for both writes and reads.
- R3: A configuration write sets enable from data bit 0 and continuous mode from data bit 1. When bit 0 is 1, the write loads the counter from the start value. A write of zero stops the channel, the live count then holds, and no interrupt follows.
- R4: While enabled, the counter decrements on each tick. On a tick that finds it at zero, the channel sets pending. With a start value S written at edge w, irq rises at edge T+S·DIV, where T is the first tick edge after w (a period of S+1 ticks).
- R5: In one-shot mode (bit 1 clear), the channel clears its enable bit on the tick that fires it and its count stays at zero.
- R6: In continuous mode, the counter reloads the start value on the firing tick and keeps counting, and enable stays set.
- R7: Pending drives the channel's level irq output and stays set until any write to that channel's configuration register clears it. A configuration write takes precedence over a tick on the same edge.
- R8: The start value field is 23 bits wide (maximum 0x7FFFFF), and written bits above bit 22 are dropped. Writing the start value does not disturb a running count.
- R9: A configuration read returns enable in bit 0, continuous in bit 1, pending in bit 2 and zeros elsewhere. A count read returns the start value in bits [22:0], the live count in bits [54:32] and zeros elsewhere. Reads are combinational from the address.
- R10: Channels are independent, and irq[c] is driven only by channel c.
- R11: After reset, all registers and counts are zero and every irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address (6 bits for four channels) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq | output | NCH | Level interrupt per channel, bit c from channel c |

## Verification
A write lands on the edge where bus_wr is sampled. The irq output and all read fields change on that edge for configuration effects, and on tick edges (multiples of DIV) for counting effects. Read data follows the address in the same cycle. The bench numbers every clock edge from reset release and drives inputs on falling edges, so each stimulus lands on a known edge. It computes each expected irq rise edge arithmetically as the next multiple of DIV after the write edge plus the start value times DIV, and it compares against the edge on which irq is first seen high. Read-backs and level checks are sampled one delta after a falling edge, so they always reflect a completed edge.

// File: rtl/itb_pkg.sv
package itb_pkg;
    localparam int CNT_W = 23;
    localparam int REG_W = 64;

    typedef struct packed {
        logic             en;
        logic             cont;
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] init;
    } chan_state_t;
endpackage

// File: rtl/itb_tick_gen.sv
module itb_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    assign tick = (pre_q == PW'(DIV - 1));

    always_comb begin
        pre_d = tick ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/itb_channel.sv
module itb_channel
    import itb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] init_data,
    output logic             en,
    output logic             cont,
    output logic             pend,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] init
);
    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cnt_wr) s_d.init = init_data;
        if (cfg_wr) begin
            s_d.en   = cfg_data[0];
            s_d.cont = cfg_data[1];
            s_d.pend = 1'b0;
            if (cfg_data[0]) s_d.cnt = s_q.init;
        end else if (tick && s_q.en) begin
            if (s_q.cnt == '0) begin
                s_d.pend = 1'b1;
                if (s_q.cont) s_d.cnt = s_q.init;
                else          s_d.en  = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en   = s_q.en;
    assign cont = s_q.cont;
    assign pend = s_q.pend;
    assign cnt  = s_q.cnt;
    assign init = s_q.init;

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !pend);
    p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cfg_wr) |=> pend);
    p_oneshot_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !cont && cnt == '0 && !cfg_wr) |=> (!en && pend));
    p_cont_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && cont && cnt == '0 && !cfg_wr && !cnt_wr) |=> (en && cnt == $past(init)));
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_wr) |=> $stable(cnt));
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
    import itb_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DIV    = 100,
    parameter int CW     = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int ADDR_W = CW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);
    logic             tick;
    logic [CW-1:0]    sel;
    logic             reg_sel;
    logic [NCH-1:0]   en_w, cont_w, pend_w, cfg_wr, cnt_wr;
    logic [CNT_W-1:0] cnt_w  [NCH];
    logic [CNT_W-1:0] init_w [NCH];
    logic             unused_bits;

    assign sel         = bus_addr[ADDR_W-1:4];
    assign reg_sel     = bus_addr[3];
    assign unused_bits = ^{bus_addr[2:0], bus_wdata[REG_W-1:CNT_W]};

    itb_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign cfg_wr[c] = bus_wr && (sel == CW'(c)) && !reg_sel;
            assign cnt_wr[c] = bus_wr && (sel == CW'(c)) &&  reg_sel;

            itb_channel u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .cfg_wr    (cfg_wr[c]),
                .cfg_data  (bus_wdata[1:0]),
                .cnt_wr    (cnt_wr[c]),
                .init_data (bus_wdata[CNT_W-1:0]),
                .en        (en_w[c]),
                .cont      (cont_w[c]),
                .pend      (pend_w[c]),
                .cnt       (cnt_w[c]),
                .init      (init_w[c])
            );
        end
    endgenerate

    assign irq = pend_w;

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel == CW'(c)) begin
                if (reg_sel) begin
                    bus_rdata[CNT_W-1:0]     = init_w[c];
                    bus_rdata[32 +: CNT_W]   = cnt_w[c];
                end else begin
                    bus_rdata[2:0] = {pend_w[c], cont_w[c], en_w[c]};
                end
            end
        end
    end

    p_irq_needs_write_or_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_wr) |=> $stable(irq));
endmodule

// File: tb/interval_timer_bank_tb.sv
module interval_timer_bank_tb;
    localparam int PERIOD = 10;
    localparam int NCH    = 4;
    localparam int DIV    = 4;
    localparam int AW     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [NCH-1:0] irq;

    int edge_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    interval_timer_bank #(.NCH(NCH), .DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] adr(input int ch, input bit r, input logic [2:0] lo);
        return {ch[1:0], r, lo};
    endfunction

    function automatic int t_next(input int w);
        return (w / DIV + 1) * DIV;
    endfunction

    task automatic wr(input int ch, input bit r, input logic [63:0] d, output int w);
        bus_wr = 1'b1; bus_addr = adr(ch, r, 3'b000); bus_wdata = d;
        w = edge_cnt + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_lo(input int ch, input bit r, input logic [2:0] lo, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = adr(ch, r, lo); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input bit r, input logic [2:0] lo, output logic [63:0] d);
        bus_addr = adr(ch, r, lo);
        #1 d = bus_rdata;
    endtask

    task automatic wait_rise(input int ch, output int e);
        e = -1;
        for (int i = 0; i < 400; i++) begin
            #1;
            if (irq[ch]) begin e = edge_cnt; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_edge(input int target);
        while (edge_cnt < target) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, d2;
        int w, e, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        #1 chk(irq == '0, "R11 irq", irq, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, 0, 3'b000, d); chk(d == 0, "R11 cfg", d, 0);
            rd(c, 1, 3'b000, d); chk(d == 0, "R11 cnt", d, 0);
        end
        @(negedge clk);

        // R4 R5 R7 R9 R10: one-shot sweep
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s <= 4; s++) begin
                wr(c, 1, 64'(s), w);
                wr(c, 0, 64'h1, w);
                wait_rise(c, e);
                chk(e == t_next(w) + s * DIV, "R4 fire edge", e, t_next(w) + s * DIV);
                chk((irq & ~(4'(1) << c)) == '0, "R10 other irq", irq, 0);
                rd(c, 0, 3'b000, d); chk(d == 64'h4, "R5 R9 cfg after fire", d, 64'h4);
                repeat (2 * DIV) @(negedge clk);
                rd(c, 1, 3'b000, d); chk(d == 64'(s), "R5 count stays zero", d, 64'(s));
                #1 chk(irq[c] == 1'b1, "R7 level held", irq[c], 1);
                wr(c, 0, 64'h0, w);
                #1 chk(irq[c] == 1'b0, "R7 ack clears", irq[c], 0);
            end
        end

        // R6: continuous mode on channel 2, start 3
        wr(2, 1, 64'h3, w);
        wr(2, 0, 64'h3, w);
        wait_rise(2, e);
        chk(e == t_next(w) + 3 * DIV, "R6 first fire", e, t_next(w) + 3 * DIV);
        wait_edge(e + DIV);
        rd(2, 1, 3'b000, d); chk(d[54:32] == 23'd2, "R6 reload and count", d[54:32], 2);
        rd(2, 0, 3'b000, d); chk(d == 64'h7, "R6 R9 cfg running", d, 64'h7);
        wait_edge(e + 4 * DIV);
        rd(2, 1, 3'b000, d); chk(d[54:32] == 23'd3, "R6 second reload", d[54:32], 3);
        wr(2, 0, 64'h3, a);
        #1 chk(irq[2] == 1'b0, "R7 ack in continuous", irq[2], 0);
        wait_rise(2, e);
        chk(e == t_next(a) + 3 * DIV, "R3 rewrite reloads", e, t_next(a) + 3 * DIV);

        // R3: stop holds count
        wr(2, 0, 64'h0, w);
        wait_edge(w + DIV + 1);
        rd(2, 1, 3'b000, d);
        repeat (3 * DIV) @(negedge clk);
        rd(2, 1, 3'b000, d2); chk(d2 == d, "R3 stopped count holds", d2, d);
        #1 chk(irq[2] == 1'b0, "R3 stopped no irq", irq[2], 0);

        // R3: stop mid-count, no irq
        wr(0, 1, 64'h5, w);
        wr(0, 0, 64'h1, w);
        repeat (DIV + 1) @(negedge clk);
        wr(0, 0, 64'h0, w);
        repeat (8 * DIV) @(negedge clk);
        #1 chk(irq[0] == 1'b0, "R3 mid-count stop", irq[0], 0);

        // R8: start value write while running, width truncation
        wr(1, 1, 64'h4, w);
        wr(1, 0, 64'h1, w);
        wr(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, a);
        rd(1, 1, 3'b000, d); chk(d[31:0] == 32'h7FFFFF, "R8 width", d[31:0], 32'h7FFFFF);
        wait_rise(1, e);
        chk(e == t_next(w) + 4 * DIV, "R8 running count undisturbed", e, t_next(w) + 4 * DIV);
        wr(1, 0, 64'h0, w);

        // R2: low address bits ignored
        wr_lo(3, 1, 3'b101, 64'h2A);
        rd(3, 1, 3'b010, d); chk(d == 64'h2A, "R2 offset ignored", d, 64'h2A);
        rd(2, 1, 3'b000, d2); chk(d2[22:0] == 23'h3, "R2 channel isolation", d2[22:0], 3);

        // R7: write beats tick on the same edge, start 0 continuous
        wr(3, 1, 64'h0, w);
        wr(3, 0, 64'h3, w);
        wait_rise(3, e);
        while (((edge_cnt + 1) % DIV) != 0) @(negedge clk);
        wr(3, 0, 64'h3, a);
        #1 chk(irq[3] == 1'b0, "R7 write precedence", irq[3], 0);
        wait_rise(3, e);
        chk(e == a + DIV, "R7 next fire after precedence", e, a + DIV);
        wr(3, 0, 64'h0, w);

        // R1: tick spacing seen via start 0 one-shot
        for (int k = 0; k < DIV; k++) begin
            wr(0, 1, 64'h0, w);
            wr(0, 0, 64'h1, w);
            wait_rise(0, e);
            chk((e % DIV) == 0 && e == t_next(w), "R1 tick edge", e, t_next(w));
            wr(0, 0, 64'h0, w);
            repeat (k) @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule